// File: doc/BRIEF.md
# Parallel Issue Packet Legality Checker

This block inspects a group of up to eight instructions that a dual-cluster processor wants to issue together in one cycle. Each cluster (side A and side B) owns a register file and four execution units: a multiplier, an arithmetic/logic unit, a shift/branch unit and a data/address unit. Each slot of the packet describes one instruction. It gives the unit it is routed to, whether it borrows the other side's operand bus, whether it is a memory access, which register sides it touches, which registers it reads and which register it writes.

The checker applies the cluster resource rules to every valid slot. It reports one violation bit per rule and a single legality bit that is set only when no rule is broken. The result is registered, so it appears at the outputs one clock edge after the packet is presented. Slots whose valid bit is low take no part in any rule. The block does not decode or execute instructions. It only decides whether a packet may issue as a whole.

Top module: `pkt_issue_checker`

## Requirements
- R1: Unit codes are 3 bits: bit 2 is the side (0 = A, 1 = B) and bits 1:0 are the kind (0 multiply, 1 logic/arith, 2 shift/branch, 3 data/address). When two valid slots name the same unit code, violation bit 0 is set.
- R2: Register indices are 5 bits, and bit 4 gives the side. When a valid non-memory slot has its write enable set and its destination side differs from its unit's side, violation bit 1 is set.
- R3: Violation bit 2 is set in either of two cases. The first is that two or more valid slots whose units are on the same side set the operand-bus-borrow flag. The second is that a valid slot on a data/address unit sets that flag. One borrowing slot per side is legal.
- R4: Violation bit 3 is set in either of two cases. The first is that a valid memory slot sits on a unit that is not a data/address unit. The second is that a valid memory slot has an address-register side that differs from its unit's side.
- R5: A memory slot is a load when its store flag is 0 and a store when it is 1. Violation bit 4 is set when, among valid slots, a load's data side equals a store's data side. A load into one side together with a store from the other side is legal.
- R6: Each slot has two read enables: bit 0 enables the first source and bit 1 enables the second. When any register index is read by more than MAX_READS (default 4) enabled operands of valid slots, violation bit 5 is set. Two operands of one slot that read the same register count twice.
- R7: When two valid slots both have their write enable set and their multi-cycle flag clear, and both name the same destination, violation bit 6 is set. The rule does not apply when either slot is multi-cycle.
- R8: Both outputs are registered. They reflect the packet that was present at the previous rising clock edge. pkt_ok is 1 exactly when all seven violation bits are 0.
- R9: A slot whose valid bit is 0 takes no part in any rule, whatever its other fields hold.
- R10: While rst is high at a rising edge, the outputs become pkt_ok = 1 and pkt_viol = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | NSLOT | Per-slot valid |
| slot_unit | input | 3*NSLOT | Per-slot unit code {side, kind} |
| slot_xp | input | NSLOT | Per-slot flag: borrows the other side's operand bus |
| slot_mem | input | NSLOT | Per-slot memory-access flag |
| slot_st | input | NSLOT | Per-slot store flag (memory slots) |
| slot_dside | input | NSLOT | Per-slot data register side (memory slots) |
| slot_aside | input | NSLOT | Per-slot address register side (memory slots) |
| slot_rd_en | input | 2*NSLOT | Per-slot read enables {second, first} |
| slot_src0 | input | 5*NSLOT | Per-slot first source register |
| slot_src1 | input | 5*NSLOT | Per-slot second source register |
| slot_we | input | NSLOT | Per-slot destination write enable |
| slot_multi | input | NSLOT | Per-slot flag: result takes more than one cycle |
| slot_dst | input | 5*NSLOT | Per-slot destination register |
| pkt_ok | output | 1 | Packet legal (registered) |
| pkt_viol | output | 7 | Per-rule violation bits (registered) |

## Verification
All rule logic is combinational and feeds one output register, so every verdict is due exactly one rising edge after its packet is applied. The bench changes the slot fields on a falling edge and computes the expected verdict from those stable values. It waits for the next rising edge, then compares pkt_ok and pkt_viol 1 ns later, after the registers have settled. The packet is held until the next falling edge, so each sample sees exactly one packet. The reset check is sampled in the same way, one edge after rst is asserted over a packet full of violations.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    localparam int UNIT_W = 3;
    localparam int REG_W  = 5;
    localparam int NVIOL  = 7;

    typedef enum logic [1:0] {
        K_MUL = 2'd0,
        K_ALU = 2'd1,
        K_SHF = 2'd2,
        K_MEM = 2'd3
    } kind_e;

    typedef struct packed {
        logic  side;
        kind_e kind;
    } unit_t;

    // Resource-related part of a slot
    typedef struct packed {
        logic  vld;
        unit_t unit;
        logic  xp;
        logic  mem;
        logic  st;
        logic  dside;
        logic  aside;
    } slot_ctl_t;

    // Register-related part of a slot
    typedef struct packed {
        logic [1:0]       rd_en;
        logic [REG_W-1:0] src0;
        logic [REG_W-1:0] src1;
        logic             we;
        logic             multi;
        logic [REG_W-1:0] dst;
    } slot_reg_t;

    // Violation bit positions
    localparam int V_UNIT  = 0;
    localparam int V_DSIDE = 1;
    localparam int V_XPATH = 2;
    localparam int V_ADDR  = 3;
    localparam int V_LDST  = 4;
    localparam int V_RDCAP = 5;
    localparam int V_WDUP  = 6;

    function automatic logic reg_side(input logic [REG_W-1:0] r);
        return r[REG_W-1];
    endfunction

    function automatic logic is_load(input slot_ctl_t s);
        return s.vld && s.mem && !s.st;
    endfunction

    function automatic logic is_store(input slot_ctl_t s);
        return s.vld && s.mem && s.st;
    endfunction

endpackage

// File: rtl/pkt_unit_rules.sv
module pkt_unit_rules
    import pkt_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  slot_ctl_t ctl [NSLOT],
    output logic      unit_dup,
    output logic      xp_bad,
    output logic      addr_bad,
    output logic      ldst_bad
);
    localparam int NUNIT = 1 << UNIT_W;
    localparam int CW    = $clog2(NSLOT + 1);

    logic [1:0] ld_side;
    logic [1:0] st_side;

    always_comb begin
        logic [CW-1:0] ucnt;
        logic [CW-1:0] xcnt [2];
        unit_dup = 1'b0;
        xp_bad   = 1'b0;
        addr_bad = 1'b0;
        ld_side  = '0;
        st_side  = '0;
        xcnt[0]  = '0;
        xcnt[1]  = '0;
        for (int u = 0; u < NUNIT; u++) begin
            ucnt = '0;
            for (int s = 0; s < NSLOT; s++)
                if (ctl[s].vld && ctl[s].unit == UNIT_W'(u))
                    ucnt = ucnt + 1'b1;
            if (ucnt > CW'(1))
                unit_dup = 1'b1;
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (ctl[s].vld && ctl[s].xp) begin
                xcnt[ctl[s].unit.side] = xcnt[ctl[s].unit.side] + 1'b1;
                if (ctl[s].unit.kind == K_MEM)
                    xp_bad = 1'b1;
            end
            if (ctl[s].vld && ctl[s].mem &&
                (ctl[s].unit.kind != K_MEM || ctl[s].aside != ctl[s].unit.side))
                addr_bad = 1'b1;
            if (is_load(ctl[s]))  ld_side[ctl[s].dside] = 1'b1;
            if (is_store(ctl[s])) st_side[ctl[s].dside] = 1'b1;
        end
        if (xcnt[0] > CW'(1) || xcnt[1] > CW'(1))
            xp_bad = 1'b1;
    end

    assign ldst_bad = |(ld_side & st_side);

    // R1
    pair_unit_dup_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl[0].vld && ctl[1].vld && ctl[0].unit == ctl[1].unit) |-> unit_dup);

    // R3
    pair_xp_same_side_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl[0].vld && ctl[1].vld && ctl[0].xp && ctl[1].xp &&
         ctl[0].unit.side == ctl[1].unit.side) |-> xp_bad);

    // R5
    pair_ldst_chk: assert property (@(posedge clk) disable iff (rst)
        (is_load(ctl[0]) && is_store(ctl[1]) && ctl[0].dside == ctl[1].dside) |-> ldst_bad);

endmodule

// File: rtl/pkt_reg_rules.sv
module pkt_reg_rules
    import pkt_pkg::*;
#(
    parameter int NSLOT     = 8,
    parameter int MAX_READS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vld  [NSLOT],
    input  logic       side [NSLOT],
    input  logic       mem  [NSLOT],
    input  slot_reg_t  regs [NSLOT],
    output logic       dside_bad,
    output logic       rdcap_bad,
    output logic       wdup_bad
);
    localparam int NREG = 1 << REG_W;
    localparam int CW   = $clog2(2 * NSLOT + 1);

    logic [NREG-1:0]  over;
    logic [NSLOT-1:0] vld_vec;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [CW-1:0] nrd;
        always_comb begin
            nrd = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (vld[s] && regs[s].rd_en[0] && regs[s].src0 == REG_W'(r))
                    nrd = nrd + 1'b1;
                if (vld[s] && regs[s].rd_en[1] && regs[s].src1 == REG_W'(r))
                    nrd = nrd + 1'b1;
            end
        end
        assign over[r] = (nrd > CW'(MAX_READS));
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_vld
        assign vld_vec[s] = vld[s];
    end

    assign rdcap_bad = |over;

    always_comb begin
        dside_bad = 1'b0;
        wdup_bad  = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (vld[i] && regs[i].we && !mem[i] && reg_side(regs[i].dst) != side[i])
                dside_bad = 1'b1;
            for (int j = i + 1; j < NSLOT; j++)
                if (vld[i] && vld[j] && regs[i].we && regs[j].we &&
                    !regs[i].multi && !regs[j].multi && regs[i].dst == regs[j].dst)
                    wdup_bad = 1'b1;
        end
    end

    // R6
    rdcap_min_slots_chk: assert property (@(posedge clk) disable iff (rst)
        rdcap_bad |-> ($countones(vld_vec) >= (MAX_READS + 2) / 2));

    // R7
    pair_wdup_chk: assert property (@(posedge clk) disable iff (rst)
        (vld[0] && vld[1] && regs[0].we && regs[1].we && !regs[0].multi &&
         !regs[1].multi && regs[0].dst == regs[1].dst) |-> wdup_bad);

    // R9
    idle_no_rdcap_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_vec == '0) |-> !rdcap_bad && !wdup_bad && !dside_bad);

endmodule

// File: rtl/pkt_issue_checker.sv
module pkt_issue_checker
    import pkt_pkg::*;
#(
    parameter int NSLOT     = 8,
    parameter int MAX_READS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSLOT-1:0]          slot_vld,
    input  logic [UNIT_W*NSLOT-1:0]   slot_unit,
    input  logic [NSLOT-1:0]          slot_xp,
    input  logic [NSLOT-1:0]          slot_mem,
    input  logic [NSLOT-1:0]          slot_st,
    input  logic [NSLOT-1:0]          slot_dside,
    input  logic [NSLOT-1:0]          slot_aside,
    input  logic [2*NSLOT-1:0]        slot_rd_en,
    input  logic [REG_W*NSLOT-1:0]    slot_src0,
    input  logic [REG_W*NSLOT-1:0]    slot_src1,
    input  logic [NSLOT-1:0]          slot_we,
    input  logic [NSLOT-1:0]          slot_multi,
    input  logic [REG_W*NSLOT-1:0]    slot_dst,
    output logic                      pkt_ok,
    output logic [NVIOL-1:0]          pkt_viol
);
    slot_ctl_t ctl  [NSLOT];
    slot_reg_t regs [NSLOT];
    logic      vld  [NSLOT];
    logic      side [NSLOT];
    logic      mem  [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign ctl[s].vld   = slot_vld[s];
        assign ctl[s].unit  = unit_t'(slot_unit[UNIT_W*s +: UNIT_W]);
        assign ctl[s].xp    = slot_xp[s];
        assign ctl[s].mem   = slot_mem[s];
        assign ctl[s].st    = slot_st[s];
        assign ctl[s].dside = slot_dside[s];
        assign ctl[s].aside = slot_aside[s];
        assign regs[s].rd_en = slot_rd_en[2*s +: 2];
        assign regs[s].src0  = slot_src0[REG_W*s +: REG_W];
        assign regs[s].src1  = slot_src1[REG_W*s +: REG_W];
        assign regs[s].we    = slot_we[s];
        assign regs[s].multi = slot_multi[s];
        assign regs[s].dst   = slot_dst[REG_W*s +: REG_W];
        assign vld[s]  = slot_vld[s];
        assign side[s] = slot_unit[UNIT_W*s + UNIT_W - 1];
        assign mem[s]  = slot_mem[s];
    end

    logic [NVIOL-1:0] viol_now;

    pkt_unit_rules #(.NSLOT(NSLOT)) i_unit_rules (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .unit_dup (viol_now[V_UNIT]),
        .xp_bad   (viol_now[V_XPATH]),
        .addr_bad (viol_now[V_ADDR]),
        .ldst_bad (viol_now[V_LDST])
    );

    pkt_reg_rules #(.NSLOT(NSLOT), .MAX_READS(MAX_READS)) i_reg_rules (
        .clk       (clk),
        .rst       (rst),
        .vld       (vld),
        .side      (side),
        .mem       (mem),
        .regs      (regs),
        .dside_bad (viol_now[V_DSIDE]),
        .rdcap_bad (viol_now[V_RDCAP]),
        .wdup_bad  (viol_now[V_WDUP])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_ok   <= 1'b1;
            pkt_viol <= '0;
        end else begin
            pkt_ok   <= (viol_now == '0);
            pkt_viol <= viol_now;
        end
    end

    // R10
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (pkt_ok && pkt_viol == '0));

    // R8
    viol_blocks_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_now != '0) |=> !pkt_ok);

    // R9
    empty_pkt_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld == '0) |=> (pkt_ok && pkt_viol == '0));

endmodule

// File: tb/test_pkt_issue_checker.sv
`timescale 1ns/1ps
module test_pkt_issue_checker;
    localparam int NS = 8;
    localparam int MAXR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       b_vld [NS];
    logic [2:0] b_unit[NS];
    logic       b_xp  [NS];
    logic       b_mem [NS];
    logic       b_st  [NS];
    logic       b_ds  [NS];
    logic       b_as  [NS];
    logic [1:0] b_rd  [NS];
    logic [4:0] b_s0  [NS];
    logic [4:0] b_s1  [NS];
    logic       b_we  [NS];
    logic       b_mc  [NS];
    logic [4:0] b_dst [NS];

    logic [NS-1:0]   f_vld, f_xp, f_mem, f_st, f_ds, f_as, f_we, f_mc;
    logic [3*NS-1:0] f_unit;
    logic [2*NS-1:0] f_rd;
    logic [5*NS-1:0] f_s0, f_s1, f_dst;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            f_vld[i] = b_vld[i];
            f_xp[i]  = b_xp[i];
            f_mem[i] = b_mem[i];
            f_st[i]  = b_st[i];
            f_ds[i]  = b_ds[i];
            f_as[i]  = b_as[i];
            f_we[i]  = b_we[i];
            f_mc[i]  = b_mc[i];
            f_unit[3*i +: 3] = b_unit[i];
            f_rd[2*i +: 2]   = b_rd[i];
            f_s0[5*i +: 5]   = b_s0[i];
            f_s1[5*i +: 5]   = b_s1[i];
            f_dst[5*i +: 5]  = b_dst[i];
        end
    end

    logic       pkt_ok;
    logic [6:0] pkt_viol;

    pkt_issue_checker #(.NSLOT(NS), .MAX_READS(MAXR)) i_pkt_issue_checker (
        .clk(clk), .rst(rst),
        .slot_vld(f_vld), .slot_unit(f_unit), .slot_xp(f_xp), .slot_mem(f_mem),
        .slot_st(f_st), .slot_dside(f_ds), .slot_aside(f_as), .slot_rd_en(f_rd),
        .slot_src0(f_s0), .slot_src1(f_s1), .slot_we(f_we), .slot_multi(f_mc),
        .slot_dst(f_dst), .pkt_ok(pkt_ok), .pkt_viol(pkt_viol)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic clear_pkt();
        for (int i = 0; i < NS; i++) begin
            b_vld[i] = 0; b_unit[i] = 3'd0; b_xp[i] = 0; b_mem[i] = 0;
            b_st[i] = 0; b_ds[i] = 0; b_as[i] = 0; b_rd[i] = 2'b00;
            b_s0[i] = 5'd0; b_s1[i] = 5'd0; b_we[i] = 0; b_mc[i] = 0; b_dst[i] = 5'd0;
        end
    endtask

    // One slot per unit; data/address units load into their own side.
    task automatic legal_pkt();
        for (int i = 0; i < NS; i++) begin
            logic sd;
            sd = (i >= 4);
            b_vld[i] = 1; b_unit[i] = 3'(i); b_xp[i] = 0;
            b_mem[i] = (i % 4 == 3); b_st[i] = 0; b_ds[i] = sd; b_as[i] = sd;
            b_rd[i]  = b_mem[i] ? 2'b01 : 2'b11;
            b_s0[i]  = {sd, 4'(i % 4)};
            b_s1[i]  = {sd, 4'(8 + i % 4)};
            b_we[i]  = 1; b_mc[i] = b_mem[i];
            b_dst[i] = {sd, 4'(4 + i % 4)};
        end
    endtask

    function automatic logic [6:0] exp_viol();
        logic [6:0] v;
        v = '0;
        for (int i = 0; i < NS; i++) begin
            if (!b_vld[i]) continue;
            if (b_we[i] && !b_mem[i] && b_dst[i][4] != b_unit[i][2]) v[1] = 1;
            if (b_xp[i] && b_unit[i][1:0] == 2'd3) v[2] = 1;
            if (b_mem[i] && (b_unit[i][1:0] != 2'd3 || b_as[i] != b_unit[i][2])) v[3] = 1;
            for (int j = i + 1; j < NS; j++) begin
                if (!b_vld[j]) continue;
                if (b_unit[i] == b_unit[j]) v[0] = 1;
                if (b_xp[i] && b_xp[j] && b_unit[i][2] == b_unit[j][2]) v[2] = 1;
                if (b_mem[i] && b_mem[j] && b_st[i] != b_st[j] && b_ds[i] == b_ds[j]) v[4] = 1;
                if (b_we[i] && b_we[j] && !b_mc[i] && !b_mc[j] && b_dst[i] == b_dst[j]) v[6] = 1;
            end
            for (int k = 0; k < 2; k++) begin
                logic [4:0] r;
                int cnt;
                if (!b_rd[i][k]) continue;
                r = k ? b_s1[i] : b_s0[i];
                cnt = 0;
                for (int j = 0; j < NS; j++) begin
                    if (!b_vld[j]) continue;
                    if (b_rd[j][0] && b_s0[j] == r) cnt++;
                    if (b_rd[j][1] && b_s1[j] == r) cnt++;
                end
                if (cnt > MAXR) v[5] = 1;
            end
        end
        return v;
    endfunction

    task automatic compare(string tag, logic [6:0] ev);
        logic eok;
        eok = (ev == '0);
        checks++;
        if (pkt_ok !== eok || pkt_viol !== ev) begin
            failures++;
            $display("FAIL %s: ok=%0b viol=%b expected ok=%0b viol=%b",
                     tag, pkt_ok, pkt_viol, eok, ev);
        end
    endtask

    // Inputs were set after a falling edge; result is due after the next rising edge.
    task automatic check_pkt(string tag);
        logic [6:0] ev;
        ev = exp_viol();
        @(posedge clk);
        #1;
        compare(tag, ev);
    endtask

    task automatic start_legal();
        @(negedge clk);
        legal_pkt();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_pkt();
        rst = 1'b1;
        // R10: reset with a packet full of violations present
        @(negedge clk);
        legal_pkt();
        b_unit[1] = 3'd0; b_xp[0] = 1; b_xp[1] = 1;
        @(posedge clk); #1;
        compare("R10 reset state", 7'd0);
        @(posedge clk); #1;
        compare("R10 reset held", 7'd0);
        @(negedge clk);
        rst = 1'b0;
        clear_pkt();
        check_pkt("R9 empty packet");

        start_legal(); check_pkt("R8 legal full packet");

        start_legal(); b_unit[1] = 3'd0; check_pkt("R1 duplicate unit");
        start_legal(); b_unit[5] = 3'd4; b_dst[5] = 5'h1E; check_pkt("R1 duplicate unit side B");

        start_legal(); b_dst[0] = 5'h10; check_pkt("R2 destination on other side");
        start_legal(); b_dst[3] = 5'h1F; check_pkt("R2 memory slot exempt");

        start_legal(); b_xp[0] = 1; b_xp[1] = 1; check_pkt("R3 two borrows side A");
        start_legal(); b_xp[0] = 1; b_xp[4] = 1; check_pkt("R3 one borrow per side legal");
        start_legal(); b_xp[3] = 1; check_pkt("R3 borrow on data unit");

        start_legal(); b_as[3] = 1; check_pkt("R4 address side mismatch");
        start_legal(); b_mem[0] = 1; b_mc[0] = 1; check_pkt("R4 memory on multiply unit");

        start_legal(); b_st[7] = 1; b_ds[7] = 0; b_we[7] = 0; check_pkt("R5 load A with store A");
        start_legal(); b_st[7] = 1; b_we[7] = 0; check_pkt("R5 load A with store B legal");

        start_legal(); b_s0[0] = 5'd2; b_s0[1] = 5'd2; b_s0[4] = 5'd2; b_s0[5] = 5'd2;
        check_pkt("R6 five reads of one register");
        start_legal(); b_s0[0] = 5'd2; b_s0[1] = 5'd2; b_s0[4] = 5'd2;
        check_pkt("R6 four reads legal");
        start_legal(); b_s0[0] = 5'd2; b_s1[0] = 5'd2; b_s0[1] = 5'd2; b_s1[1] = 5'd2;
        check_pkt("R6 same-slot operands count twice");
        start_legal(); b_s0[0] = 5'd2; b_s0[1] = 5'd2; b_s0[4] = 5'd2; b_s0[5] = 5'd2;
        b_rd[5] = 2'b10; check_pkt("R6 disabled read not counted");

        start_legal(); b_dst[1] = b_dst[0]; check_pkt("R7 two single-cycle writes");
        start_legal(); b_dst[1] = b_dst[0]; b_mc[1] = 1; check_pkt("R7 multi-cycle exempt");
        start_legal(); b_dst[3] = b_dst[0]; check_pkt("R7 load and single-cycle legal");

        start_legal(); b_vld[1] = 0; b_unit[1] = 3'd0; b_dst[1] = b_dst[0]; b_xp[1] = 1;
        b_xp[0] = 1; check_pkt("R9 invalid slot ignored");
        start_legal(); b_vld[7] = 0; b_st[7] = 1; b_ds[7] = 0; b_as[7] = 0;
        check_pkt("R9 invalid store ignored");

        start_legal(); b_unit[1] = 3'd0; b_as[3] = 1; b_dst[2] = b_dst[0];
        check_pkt("R8 several violations");

        for (int n = 0; n < 500; n++) begin
            @(negedge clk);
            for (int i = 0; i < NS; i++) begin
                b_vld[i]  = ($urandom % 3) != 0;
                b_unit[i] = 3'($urandom);
                b_xp[i]   = ($urandom % 6) == 0;
                b_mem[i]  = (b_unit[i][1:0] == 2'd3) ? 1'($urandom) : (($urandom % 16) == 0);
                b_st[i]   = 1'($urandom);
                b_ds[i]   = 1'($urandom);
                b_as[i]   = (($urandom % 5) == 0) ? ~b_unit[i][2] : b_unit[i][2];
                b_rd[i]   = 2'($urandom);
                b_s0[i]   = {1'($urandom), 4'($urandom % 3)};
                b_s1[i]   = {1'($urandom), 4'($urandom % 3)};
                b_we[i]   = 1'($urandom);
                b_mc[i]   = 1'($urandom);
                b_dst[i]  = (($urandom % 4) == 0) ? {~b_unit[i][2], 4'($urandom % 4)}
                                                  : {b_unit[i][2], 4'($urandom % 4)};
            end
            check_pkt("random mix");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule